// File: doc/BRIEF.md
# Manchester Line Encoder for 10 Mbit/s Transmit

This block turns an NRZ bit stream from a media access controller into a Manchester coded signal on a two-leg digital line pair. It runs from a 20 MHz reference clock and divides that clock by two to produce the 10 MHz transmit clock it hands back to the controller. The controller changes its transmit-enable and data inputs in step with that clock. Each bit cell lasts two reference cycles, and each half of a cell lasts one reference cycle.

A small state machine runs the block. IDLE holds the line at its rest level. SEND codes one bit cell per transmit-clock period. HOLD keeps the positive leg high for a short fixed tail after the last cell. The transitions are as follows. IDLE goes to SEND when enable is seen high at a capture edge. SEND stays in SEND while enable stays high, and goes to HOLD when enable is seen low. HOLD goes to SEND if enable is seen high again at a capture edge, and goes to IDLE once the tail counter expires. A mode input selects the rest level. When it is low, the positive leg rests above the negative leg. When it is high, both legs rest low, so the differential voltage is zero.

Top module: `mtx_encoder`

## Requirements
- R1: `tx_clk` is low during reset and toggles on every rising `clk_ref` edge after reset, so it runs at half the reference rate.
- R2: `tx_en` and `tx_nrz` are sampled only at a capture edge, which is the `clk_ref` edge where `tx_clk` goes from 0 to 1. A new bit cell begins on the line at that same edge.
- R3: While a cell is sent, a 1 puts `line_p` low for the first reference cycle and high for the second. A 0 puts `line_p` high for the first reference cycle and low for the second. `line_n` is the complement of `line_p` throughout.
- R4: A frame starts when `tx_en` is seen high at a capture edge. While `tx_en` stays low in IDLE, changes on `tx_nrz` leave both legs unchanged.
- R5: A frame ends when `tx_en` is seen low at a capture edge, and its last transition is always low-to-high. After a final 1 the line is already high from mid-cell. After a final 0 the line rises at the cell boundary.
- R6: After the last cell, `line_p`=1 and `line_n`=0 for exactly HOLD_CYC reference cycles (default 3, which is 150 ns; at most 4, which is 200 ns). The line then enters idle.
- R7: In idle with `idle_equal`=0, the outputs are `line_p`=1 and `line_n`=0. In idle with `idle_equal`=1, both legs are 0. The mode input does not alter cells that are being sent.
- R8: If `tx_en` is seen high at a capture edge during the HOLD tail, the next frame starts its first cell at once. This lets frames run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 20 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable, driven in step with `tx_clk` |
| tx_nrz | input | 1 | NRZ transmit data, driven in step with `tx_clk` |
| idle_equal | input | 1 | Idle mode: 0 means positive leg above negative, 1 means both legs equal |
| tx_clk | output | 1 | 10 MHz transmit clock for the controller |
| line_p | output | 1 | Positive leg of the line pair |
| line_n | output | 1 | Negative leg of the line pair |

## Verification
When a bit is captured at edge E, its first half is visible from E and its second half from E+1. The next capture edge is E+2. When enable is seen low at E, the line holds high from E through E+HOLD_CYC-1 and shows the idle level from E+HOLD_CYC. The bench sets its inputs on falling edges where `tx_clk` is 0, so the next rising edge is always a capture edge. It samples every output on the falling edge that follows each rising edge. In this way each expected half-cell, tail cycle and idle value is compared in exactly the cycle it is due.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_SEND = 2'd1,
        TS_HOLD = 2'd2
    } tx_state_e;
endpackage

// File: rtl/mtx_clkdiv.sv
module mtx_clkdiv (
    input  logic clk,
    input  logic rst_n,
    output logic div_clk,
    output logic cap_stb
);
    logic ph_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ~ph_q;
    end

    // the edge where ph_q is low is the one that raises div_clk
    assign div_clk = ph_q;
    assign cap_stb = ~ph_q;
endmodule

// File: rtl/mtx_hold_timer.sv
module mtx_hold_timer #(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (start)            cnt_q <= '0;
        else if (run && !done)     cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LAST);
endmodule

// File: rtl/mtx_encoder.sv
module mtx_encoder #(
    parameter int HOLD_CYC = 3
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic tx_en,
    input  logic tx_nrz,
    input  logic idle_equal,
    output logic tx_clk,
    output logic line_p,
    output logic line_n
);
    import mtx_pkg::*;

    tx_state_e st_q, st_d;
    logic      cap_stb;
    logic      bit_q;
    logic      tail_done;
    logic      tail_start;

    mtx_clkdiv u_div (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .div_clk (tx_clk),
        .cap_stb (cap_stb)
    );

    assign tail_start = (st_q == TS_SEND) && cap_stb && !tx_en;

    mtx_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_tail (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .start (tail_start),
        .run   (st_q == TS_HOLD),
        .done  (tail_done)
    );

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_IDLE: if (cap_stb && tx_en) st_d = TS_SEND;
            TS_SEND: if (cap_stb && !tx_en) st_d = TS_HOLD;
            TS_HOLD: begin
                if (cap_stb && tx_en) st_d = TS_SEND;
                else if (tail_done)   st_d = TS_IDLE;
            end
            default: st_d = TS_IDLE;
        endcase
    end

    // state register and captured cell bit
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            st_q  <= TS_IDLE;
            bit_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (cap_stb && tx_en) bit_q <= tx_nrz;
        end
    end

    // line outputs: tx_clk high marks the first half of a cell
    always_comb begin
        unique case (st_q)
            TS_SEND: begin
                line_p = tx_clk ? ~bit_q : bit_q;
                line_n = ~line_p;
            end
            TS_HOLD: begin
                line_p = 1'b1;
                line_n = 1'b0;
            end
            default: begin
                line_p = ~idle_equal;
                line_n = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mtx_encoder_chk.sv
module mtx_encoder_chk #(
    parameter int HOLD_CYC = 3
) (
    input logic                clk_ref,
    input logic                rst_n,
    input logic                tx_en,
    input logic                tx_clk,
    input logic                line_p,
    input logic                line_n,
    input mtx_pkg::tx_state_e  st_q
);
    import mtx_pkg::*;

    logic [3:0] hold_run;

    always_ff @(posedge clk_ref) begin
        if (!rst_n)              hold_run <= '0;
        else if (st_q != TS_HOLD) hold_run <= '0;
        else if (hold_run != 4'hF) hold_run <= hold_run + 1'b1;
    end

    assert_clk_toggles_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
        1'b1 |=> (tx_clk != $past(tx_clk)));

    assert_legs_not_both_high_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !(line_p && line_n));

    assert_end_rises_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (st_q == TS_SEND && !tx_clk && !tx_en) |=> (line_p && !line_n));

    assert_tail_bounded_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (int'(hold_run) <= HOLD_CYC));

    assert_tail_restart_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (st_q == TS_HOLD && !tx_clk && tx_en) |=> (st_q == TS_SEND && line_p != line_n));
endmodule

bind mtx_encoder mtx_encoder_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .tx_clk  (tx_clk),
    .line_p  (line_p),
    .line_n  (line_n),
    .st_q    (st_q)
);

// File: tb/mtx_encoder_bench.sv
module mtx_encoder_bench;
    localparam int HOLD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic tx_nrz = 1'b0;
    logic idle_equal = 1'b0;
    logic tx_clk, line_p, line_n;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mtx_encoder #(.HOLD_CYC(HOLD)) u_mtx_encoder (
        .clk_ref    (clk_ref_w),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .tx_nrz     (tx_nrz),
        .idle_equal (idle_equal),
        .tx_clk     (tx_clk),
        .line_p     (line_p),
        .line_n     (line_n)
    );

    logic clk_ref_w;
    assign clk_ref_w = clk;

    task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            finish_run();
        end
    end

    // align to a falling edge after which the next rising edge captures
    task automatic sync_cap();
        @(negedge clk);
        while (tx_clk !== 1'b0) @(negedge clk);
    endtask

    // send n cells, MSB first; starts at a falling edge with tx_clk low
    task automatic send_cells(input logic [7:0] bits, input int n, input string tag);
        for (int i = n - 1; i >= 0; i--) begin
            tx_en  = 1'b1;
            tx_nrz = bits[i];
            @(posedge clk); @(negedge clk);
            chk({line_p, line_n}, {~bits[i], bits[i]}, {tag, " R3 first half"});
            @(posedge clk); @(negedge clk);
            chk({line_p, line_n}, {bits[i], ~bits[i]}, {tag, " R3 second half"});
        end
    endtask

    // drop enable and check the tail then idle
    task automatic end_frame(input string tag);
        tx_en  = 1'b0;
        tx_nrz = 1'b0;
        for (int k = 0; k < HOLD; k++) begin
            @(posedge clk); @(negedge clk);
            chk({line_p, line_n}, 2'b10, {tag, " R5 R6 tail high"});
        end
        @(posedge clk); @(negedge clk);
        chk({line_p, line_n}, idle_equal ? 2'b00 : 2'b10, {tag, " R6 R7 idle after tail"});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({tx_clk, 1'b0}, 2'b00, "R1 tx_clk low in reset");
        chk({line_p, line_n}, 2'b10, "R7 reset idle level");
        rst_n = 1'b1;
    endtask

    task automatic t_clock();
        logic prev;
        @(negedge clk);
        prev = tx_clk;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk({tx_clk, 1'b0}, {~prev, 1'b0}, "R1 tx_clk toggles");
            prev = tx_clk;
        end
    endtask

    task automatic t_idle_ignore();
        idle_equal = 1'b0;
        sync_cap();
        for (int k = 0; k < 6; k++) begin
            tx_nrz = ~tx_nrz;
            @(posedge clk); @(negedge clk);
            chk({line_p, line_n}, 2'b10, "R4 data ignored while disabled");
        end
        tx_nrz = 1'b0;
    endtask

    task automatic t_frame_last_one();
        idle_equal = 1'b0;
        sync_cap();
        send_cells(8'b1011, 4, "R2 frame A");
        end_frame("frame A");
    endtask

    task automatic t_frame_last_zero();
        idle_equal = 1'b1;
        @(negedge clk);
        chk({line_p, line_n}, 2'b00, "R7 equal idle both low");
        sync_cap();
        send_cells(8'b010, 3, "R4 frame B");
        // previous sample was low (last bit 0, second half); tail must rise
        end_frame("frame B");
        @(negedge clk);
        chk({line_p, line_n}, 2'b00, "R7 stays equal idle");
    endtask

    task automatic t_mode_in_frame();
        idle_equal = 1'b0;
        sync_cap();
        tx_en = 1'b1; tx_nrz = 1'b1;
        @(posedge clk); @(negedge clk);
        idle_equal = 1'b1;
        chk({line_p, line_n}, 2'b01, "R7 mode change first half");
        @(posedge clk); @(negedge clk);
        chk({line_p, line_n}, 2'b10, "R7 mode change second half");
        end_frame("frame C");
        idle_equal = 1'b0;
    endtask

    task automatic t_back_to_back();
        idle_equal = 1'b1;
        sync_cap();
        send_cells(8'b10, 2, "frame D");
        tx_en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk({line_p, line_n}, 2'b10, "R8 gap tail 1");
        @(posedge clk); @(negedge clk);
        chk({line_p, line_n}, 2'b10, "R8 gap tail 2");
        send_cells(8'b10, 2, "R8 frame E");
        end_frame("frame E");
        idle_equal = 1'b0;
    endtask

    initial begin
        t_reset();
        t_clock();
        t_idle_ignore();
        t_frame_last_one();
        t_frame_last_zero();
        t_mode_in_frame();
        t_back_to_back();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule